// File: doc/BRIEF.md
# PCM Minor-Frame Synchronizer

This block sits behind a bit synchronizer in a telemetry receive chain. It takes one recovered bit per `bit_en` strobe and finds where fixed-length minor frames begin. Each frame opens with a sync word that fills contiguous bit positions. The block slides a window of up to 33 bits over the stream and counts how many bits differ from a programmable pattern. It runs an acquisition machine with three states. In search it tests every bit position. In verify it waits for the pattern to come back exactly one frame later. In lock it tests only the expected boundaries.

A programmable number of bit errors in the sync word still counts as a match. A programmable number of confirmed repeats leads to lock. In lock, missed sync words are bridged by flywheeling on the last known timing until a programmable count of consecutive misses ends lock.

Downstream decommutation uses four outputs: a frame-start strobe, a word-zero marker, the bit index within the frame, and the acquisition state. An event pulse marks every entry into lock and every exit from it.

Top module: `pcm_frame_sync`

## Requirements
- R1: The sync length `cfg_len` is programmable from 16 to 33. The pattern sits right-aligned in `cfg_pattern`, and bit `cfg_len-1` is the first to arrive. Only the last `cfg_len` received bits take part in a comparison.
- R2: A window is a hit when the number of positions that differ from the pattern is no greater than `cfg_tol` (0 to 15), and at least `cfg_len` bits have been received since reset.
- R3: `sync_state` encodes search as 00, verify as 01 and lock as 10. In search every received bit is tested. The first hit enters verify and sets `bit_pos` to `cfg_len-1`.
- R4: In verify, a test happens only when `bit_pos` comes back to `cfg_len-1`, which is exactly `cfg_frame_bits` bits later. When the number of hits reaches `cfg_lock_thr` the block enters lock; a value of 0 acts as 1. A miss sends the block straight to search, and testing resumes with the next bit.
- R5: In lock, each expected boundary is tested. When consecutive misses reach `cfg_loss_thr` (0 acts as 1) the block returns to search. A hit clears the miss count.
- R6: While fewer misses than the loss threshold have been seen, the block stays in lock and keeps its frame timing (flywheel).
- R7: `frame_start` is a one-cycle pulse on every boundary bit handled in lock, including the bit at which lock is entered. It does not pulse in search, in verify, or on the bit at which lock is lost.
- R8: `bit_pos` is the index within the frame of the most recent bit. The first sync bit has index 0, and the index wraps from `cfg_frame_bits-1` to 0. `bit_pos` is 0 in search. `word_zero` is high outside search whenever `bit_pos < cfg_len`.
- R9: `lock_evt` is a one-cycle pulse on every entry into lock and every exit from it.
- R10: On a cycle with `bit_en` low, the state, `bit_pos` and `word_zero` hold their values, and neither pulse fires.
- R11: While reset is active and after it is released, the block is in search and every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | Marks a valid received bit |
| bit_in | input | 1 | Received bit |
| cfg_pattern | input | 33 | Sync pattern, right-aligned |
| cfg_len | input | 6 | Sync length in bits, 16 to 33 |
| cfg_tol | input | 4 | Allowed mismatching bits |
| cfg_frame_bits | input | 15 | Minor-frame length in bits |
| cfg_lock_thr | input | 4 | Verify hits needed for lock |
| cfg_loss_thr | input | 4 | Consecutive misses needed to lose lock |
| frame_start | output | 1 | Boundary strobe while locked |
| word_zero | output | 1 | Current bit belongs to the sync word |
| sync_state | output | 2 | Acquisition state |
| bit_pos | output | 14 | Bit index within the frame |
| lock_evt | output | 1 | Lock entry or exit pulse |

## Verification
Two of the block's functions can land on the same bit. On the boundary bit where the final verify hit arrives, the block enters lock, so `frame_start` and `lock_evt` must both pulse together. On the boundary bit that holds the last allowed miss, `lock_evt` must pulse while `frame_start` stays low and the state falls to search.

The bench provokes both cases. It sends clean sync words until lock is reached, then sends sync words corrupted beyond tolerance until lock is lost. A behavioural model checks every output on every cycle, and explicit checks at those two bits judge the coincidence.

// File: rtl/pcm_fs_pkg.sv
package pcm_fs_pkg;
  typedef enum logic [1:0] {
    ST_SEARCH = 2'b00,
    ST_VERIFY = 2'b01,
    ST_LOCK   = 2'b10
  } fs_state_e;
endpackage

// File: rtl/fs_window.sv
// Sliding window of received bits plus a saturating fill count.
module fs_window #(
  parameter int MAX_SYNC = 33,
  localparam int SLEN_W = $clog2(MAX_SYNC + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bit_en,
  input  logic                bit_in,
  output logic [MAX_SYNC-1:0] win_view,
  output logic [SLEN_W-1:0]   fill_view
);
  logic [MAX_SYNC-1:0] win_q;
  logic [SLEN_W-1:0]   fill_q;

  // view including the bit being presented this cycle
  assign win_view  = {win_q[MAX_SYNC-2:0], bit_in};
  assign fill_view = (fill_q == SLEN_W'(MAX_SYNC)) ? fill_q : fill_q + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      win_q  <= '0;
      fill_q <= '0;
    end else if (bit_en) begin
      win_q  <= win_view;
      fill_q <= fill_view;
    end
  end

  // R2
  fill_cap_chk: assert property (@(posedge clk) disable iff (rst)
    fill_q <= SLEN_W'(MAX_SYNC));
endmodule

// File: rtl/fs_correlator.sv
// Masked mismatch count against the sync pattern, compared to tolerance.
module fs_correlator #(
  parameter int MAX_SYNC = 33,
  parameter int TOL_W    = 4,
  localparam int SLEN_W = $clog2(MAX_SYNC + 1)
) (
  input  logic [MAX_SYNC-1:0] win,
  input  logic [SLEN_W-1:0]   fill,
  input  logic [MAX_SYNC-1:0] pattern,
  input  logic [SLEN_W-1:0]   len,
  input  logic [TOL_W-1:0]    tol,
  output logic                hit
);
  logic [MAX_SYNC-1:0] len_mask;
  logic [MAX_SYNC-1:0] diff;
  logic [SLEN_W-1:0]   errs;

  for (genvar i = 0; i < MAX_SYNC; i++) begin : g_mask
    assign len_mask[i] = (SLEN_W'(i) < len);
  end

  assign diff = (win ^ pattern) & len_mask;

  always_comb begin
    errs = '0;
    for (int k = 0; k < MAX_SYNC; k++) begin
      errs = errs + SLEN_W'(diff[k]);
    end
  end

  assign hit = (fill >= len) && (errs <= SLEN_W'(tol));
endmodule

// File: rtl/fs_acq_fsm.sv
// Search / verify / lock machine with flywheel and registered outputs.
module fs_acq_fsm
  import pcm_fs_pkg::*;
#(
  parameter int MAX_SYNC  = 33,
  parameter int MAX_FRAME = 16384,
  parameter int THR_W     = 4,
  localparam int SLEN_W = $clog2(MAX_SYNC + 1),
  localparam int POS_W  = $clog2(MAX_FRAME),
  localparam int FLEN_W = $clog2(MAX_FRAME + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_en,
  input  logic              hit,
  input  logic [SLEN_W-1:0] cfg_len,
  input  logic [FLEN_W-1:0] cfg_frame_bits,
  input  logic [THR_W-1:0]  cfg_lock_thr,
  input  logic [THR_W-1:0]  cfg_loss_thr,
  output logic [1:0]        state_o,
  output logic [POS_W-1:0]  pos_o,
  output logic              frame_start_o,
  output logic              word_zero_o,
  output logic              lock_evt_o
);
  fs_state_e          st_q, st_d;
  logic [POS_W-1:0]   pos_q, pos_d, pos_adv, sync_end;
  logic [THR_W-1:0]   vcnt_q, vcnt_d, mcnt_q, mcnt_d, lock_eff, loss_eff;
  logic [THR_W:0]     vcnt_inc, mcnt_inc;
  logic               fs_q, fs_d, wz_q, wz_d, ev_q, ev_d, at_edge;

  assign lock_eff = (cfg_lock_thr == '0) ? THR_W'(1) : cfg_lock_thr;
  assign loss_eff = (cfg_loss_thr == '0) ? THR_W'(1) : cfg_loss_thr;
  assign vcnt_inc = {1'b0, vcnt_q} + 1'b1;
  assign mcnt_inc = {1'b0, mcnt_q} + 1'b1;
  assign sync_end = POS_W'(cfg_len) - 1'b1;
  assign pos_adv  = (FLEN_W'(pos_q) == cfg_frame_bits - 1'b1) ? '0 : pos_q + 1'b1;
  assign at_edge  = (pos_adv == sync_end);

  always_comb begin
    st_d   = st_q;
    pos_d  = pos_q;
    vcnt_d = vcnt_q;
    mcnt_d = mcnt_q;
    fs_d   = 1'b0;
    ev_d   = 1'b0;
    if (bit_en) begin
      unique case (st_q)
        ST_SEARCH: begin
          if (hit) begin
            st_d   = ST_VERIFY;
            pos_d  = sync_end;
            vcnt_d = '0;
          end
        end
        ST_VERIFY: begin
          pos_d = pos_adv;
          if (at_edge) begin
            if (!hit) begin
              st_d  = ST_SEARCH;
              pos_d = '0;
            end else if (vcnt_inc >= {1'b0, lock_eff}) begin
              st_d   = ST_LOCK;
              mcnt_d = '0;
              fs_d   = 1'b1;
              ev_d   = 1'b1;
            end else begin
              vcnt_d = vcnt_inc[THR_W-1:0];
            end
          end
        end
        ST_LOCK: begin
          pos_d = pos_adv;
          if (at_edge) begin
            fs_d = 1'b1;
            if (hit) begin
              mcnt_d = '0;
            end else if (mcnt_inc >= {1'b0, loss_eff}) begin
              st_d   = ST_SEARCH;
              pos_d  = '0;
              mcnt_d = '0;
              fs_d   = 1'b0;
              ev_d   = 1'b1;
            end else begin
              mcnt_d = mcnt_inc[THR_W-1:0];
            end
          end
        end
        default: begin
          st_d  = ST_SEARCH;
          pos_d = '0;
        end
      endcase
    end
    wz_d = (st_d != ST_SEARCH) && (pos_d < POS_W'(cfg_len));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_SEARCH;
      pos_q  <= '0;
      vcnt_q <= '0;
      mcnt_q <= '0;
      fs_q   <= 1'b0;
      wz_q   <= 1'b0;
      ev_q   <= 1'b0;
    end else begin
      st_q   <= st_d;
      pos_q  <= pos_d;
      vcnt_q <= vcnt_d;
      mcnt_q <= mcnt_d;
      fs_q   <= fs_d;
      wz_q   <= wz_d;
      ev_q   <= ev_d;
    end
  end

  assign state_o       = st_q;
  assign pos_o         = pos_q;
  assign frame_start_o = fs_q;
  assign word_zero_o   = wz_q;
  assign lock_evt_o    = ev_q;

  // R3
  legal_state_chk: assert property (@(posedge clk) disable iff (rst)
    st_q != 2'b11);

  // R4
  no_skip_verify_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(st_q) == ST_SEARCH) |-> (st_q != ST_LOCK));

  // R7
  start_in_lock_chk: assert property (@(posedge clk) disable iff (rst)
    fs_q |-> (st_q == ST_LOCK));

  // R7
  start_single_chk: assert property (@(posedge clk) disable iff (rst)
    fs_q |=> !fs_q);

  // R9
  evt_on_change_chk: assert property (@(posedge clk) disable iff (rst)
    ev_q == ((st_q == ST_LOCK) != ($past(st_q) == ST_LOCK)));

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !bit_en |=> ($stable(st_q) && $stable(pos_q) && !fs_q && !ev_q));
endmodule

// File: rtl/pcm_frame_sync.sv
module pcm_frame_sync #(
  parameter int MAX_SYNC  = 33,
  parameter int MAX_FRAME = 16384,
  parameter int TOL_W     = 4,
  parameter int THR_W     = 4,
  localparam int SLEN_W = $clog2(MAX_SYNC + 1),
  localparam int POS_W  = $clog2(MAX_FRAME),
  localparam int FLEN_W = $clog2(MAX_FRAME + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bit_en,
  input  logic                bit_in,
  input  logic [MAX_SYNC-1:0] cfg_pattern,
  input  logic [SLEN_W-1:0]   cfg_len,
  input  logic [TOL_W-1:0]    cfg_tol,
  input  logic [FLEN_W-1:0]   cfg_frame_bits,
  input  logic [THR_W-1:0]    cfg_lock_thr,
  input  logic [THR_W-1:0]    cfg_loss_thr,
  output logic                frame_start,
  output logic                word_zero,
  output logic [1:0]          sync_state,
  output logic [POS_W-1:0]    bit_pos,
  output logic                lock_evt
);
  logic [MAX_SYNC-1:0] win_view;
  logic [SLEN_W-1:0]   fill_view;
  logic                hit;

  fs_window #(.MAX_SYNC(MAX_SYNC)) u_win (
    .clk       (clk),
    .rst       (rst),
    .bit_en    (bit_en),
    .bit_in    (bit_in),
    .win_view  (win_view),
    .fill_view (fill_view)
  );

  fs_correlator #(.MAX_SYNC(MAX_SYNC), .TOL_W(TOL_W)) u_corr (
    .win     (win_view),
    .fill    (fill_view),
    .pattern (cfg_pattern),
    .len     (cfg_len),
    .tol     (cfg_tol),
    .hit     (hit)
  );

  fs_acq_fsm #(.MAX_SYNC(MAX_SYNC), .MAX_FRAME(MAX_FRAME), .THR_W(THR_W)) u_fsm (
    .clk            (clk),
    .rst            (rst),
    .bit_en         (bit_en),
    .hit            (hit),
    .cfg_len        (cfg_len),
    .cfg_frame_bits (cfg_frame_bits),
    .cfg_lock_thr   (cfg_lock_thr),
    .cfg_loss_thr   (cfg_loss_thr),
    .state_o        (sync_state),
    .pos_o          (bit_pos),
    .frame_start_o  (frame_start),
    .word_zero_o    (word_zero),
    .lock_evt_o     (lock_evt)
  );
endmodule

// File: tb/tb_pcm_frame_sync.sv
module tb_pcm_frame_sync;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bit_en = 1'b0;
  logic        bit_in = 1'b0;
  logic [32:0] cfg_pattern = 33'h0EB90;
  logic [5:0]  cfg_len = 6'd16;
  logic [3:0]  cfg_tol = 4'd2;
  logic [14:0] cfg_frame_bits = 15'd40;
  logic [3:0]  cfg_lock_thr = 4'd2;
  logic [3:0]  cfg_loss_thr = 4'd3;
  logic        frame_start, word_zero, lock_evt;
  logic [1:0]  sync_state;
  logic [13:0] bit_pos;

  int total = 0;
  int bad = 0;

  // behavioural model state
  bit hist[$];
  int m_st, m_pos, m_v, m_m, m_fs, m_wz, m_ev;

  always #5 clk = ~clk;

  pcm_frame_sync dut (
    .clk(clk), .rst(rst), .bit_en(bit_en), .bit_in(bit_in),
    .cfg_pattern(cfg_pattern), .cfg_len(cfg_len), .cfg_tol(cfg_tol),
    .cfg_frame_bits(cfg_frame_bits), .cfg_lock_thr(cfg_lock_thr),
    .cfg_loss_thr(cfg_loss_thr), .frame_start(frame_start),
    .word_zero(word_zero), .sync_state(sync_state), .bit_pos(bit_pos),
    .lock_evt(lock_evt)
  );

  task automatic check(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    hist.delete();
    m_st = 0; m_pos = 0; m_v = 0; m_m = 0; m_fs = 0; m_wz = 0; m_ev = 0;
  endtask

  function automatic bit model_hit();
    int errs = 0;
    if (hist.size() < int'(cfg_len)) return 1'b0;
    for (int i = 0; i < int'(cfg_len); i++)
      if (hist[hist.size() - 1 - i] != cfg_pattern[i]) errs++;
    return errs <= int'(cfg_tol);
  endfunction

  task automatic model_step(bit en, bit b);
    bit h;
    int lk, ls;
    m_fs = 0; m_ev = 0;
    if (!en) return;
    hist.push_back(b);
    if (hist.size() > 33) void'(hist.pop_front());
    h  = model_hit();
    lk = (cfg_lock_thr == 0) ? 1 : int'(cfg_lock_thr);
    ls = (cfg_loss_thr == 0) ? 1 : int'(cfg_loss_thr);
    if (m_st == 0) begin
      if (h) begin m_st = 1; m_pos = int'(cfg_len) - 1; m_v = 0; end
    end else begin
      m_pos = (m_pos == int'(cfg_frame_bits) - 1) ? 0 : m_pos + 1;
      if (m_pos == int'(cfg_len) - 1) begin
        if (m_st == 1) begin
          if (!h) begin m_st = 0; m_pos = 0; end
          else begin
            m_v++;
            if (m_v >= lk) begin m_st = 2; m_m = 0; m_fs = 1; m_ev = 1; end
          end
        end else begin
          m_fs = 1;
          if (h) m_m = 0;
          else begin
            m_m++;
            if (m_m >= ls) begin m_st = 0; m_pos = 0; m_fs = 0; m_ev = 1; m_m = 0; end
          end
        end
      end
    end
    m_wz = (m_st != 0 && m_pos < int'(cfg_len)) ? 1 : 0;
  endtask

  task automatic compare_all();
    check("R3", "sync_state", int'(sync_state), m_st);
    check("R8", "bit_pos", int'(bit_pos), m_pos);
    check("R8", "word_zero", int'(word_zero), m_wz);
    check("R7", "frame_start", int'(frame_start), m_fs);
    check("R9", "lock_evt", int'(lock_evt), m_ev);
  endtask

  // drive one cycle at a negedge, then compare after the posedge
  task automatic tick(bit en, bit b);
    bit_en = en;
    bit_in = b;
    model_step(en, b);
    @(negedge clk);
    compare_all();
  endtask

  task automatic zeros(int n);
    for (int i = 0; i < n; i++) tick(1'b1, 1'b0);
  endtask

  task automatic send_sync(logic [32:0] corrupt);
    for (int k = int'(cfg_len) - 1; k >= 0; k--)
      tick(1'b1, cfg_pattern[k] ^ corrupt[k]);
  endtask

  task automatic payload();
    zeros(int'(cfg_frame_bits) - int'(cfg_len));
  endtask

  task automatic do_reset();
    rst = 1'b1;
    bit_en = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    model_reset();
    @(negedge clk);
    // R11 reset state
    check("R11", "state after reset", int'(sync_state), 0);
    check("R11", "outputs after reset",
          int'(frame_start) + int'(word_zero) + int'(bit_pos) + int'(lock_evt), 0);
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int hold;
    @(negedge clk);
    do_reset();

    // ---- 16-bit pattern, frame 40, tol 2, lock 2, loss 3 ----
    zeros(10);
    send_sync(33'h0);
    check("R3", "enter verify", int'(sync_state), 1);
    check("R3", "pos at sync end", int'(bit_pos), 15);
    check("R8", "word_zero on sync", int'(word_zero), 1);
    payload();
    check("R8", "pos at frame end", int'(bit_pos), 39);
    check("R8", "word_zero in payload", int'(word_zero), 0);
    send_sync(33'h0);
    check("R4", "still verify after one hit", int'(sync_state), 1);
    check("R7", "no start in verify", int'(frame_start), 0);
    payload();
    send_sync(33'h0);
    check("R4", "lock reached", int'(sync_state), 2);
    check("R7", "start on lock entry", int'(frame_start), 1);
    check("R9", "event on lock entry", int'(lock_evt), 1);
    payload();
    send_sync(33'h00002);
    check("R2", "one error within tolerance keeps lock", int'(sync_state), 2);
    payload();
    send_sync(33'h000FF);
    check("R6", "flywheel after miss 1", int'(sync_state), 2);
    check("R6", "start during flywheel", int'(frame_start), 1);
    // R10: idle cycles hold everything
    hold = int'(bit_pos);
    tick(1'b0, 1'b1);
    tick(1'b0, 1'b0);
    check("R10", "pos held on idle", int'(bit_pos), hold);
    for (int i = 0; i < 24; i++) begin
      tick(1'b1, 1'b0);
      if (i % 5 == 0) tick(1'b0, 1'b1);
    end
    send_sync(33'h000FF);
    check("R6", "flywheel after miss 2", int'(sync_state), 2);
    payload();
    send_sync(33'h0);
    check("R5", "hit clears miss count", int'(sync_state), 2);
    for (int f = 0; f < 2; f++) begin
      payload();
      send_sync(33'h0FF00);
      check("R5", "lock held below loss threshold", int'(sync_state), 2);
    end
    payload();
    send_sync(33'h0FF00);
    check("R5", "loss after third miss", int'(sync_state), 0);
    check("R9", "event on loss", int'(lock_evt), 1);
    check("R7", "no start on loss bit", int'(frame_start), 0);
    check("R8", "pos zero in search", int'(bit_pos), 0);
    payload();
    send_sync(33'h0);
    check("R3", "reacquire to verify", int'(sync_state), 1);
    payload();
    send_sync(33'h000FF);
    check("R4", "verify miss returns to search", int'(sync_state), 0);
    for (int f = 0; f < 6; f++) begin
      payload();
      send_sync(33'h0);
    end
    check("R4", "relock after verify failure", int'(sync_state), 2);

    // ---- 24-bit pattern, frame 64, tol 0, lock 0 (acts as 1), loss 1 ----
    cfg_pattern    = 33'h0FAF320;
    cfg_len        = 6'd24;
    cfg_tol        = 4'd0;
    cfg_frame_bits = 15'd64;
    cfg_lock_thr   = 4'd0;
    cfg_loss_thr   = 4'd1;
    do_reset();
    zeros(5);
    send_sync(33'h0);
    check("R1", "24-bit pattern found", int'(sync_state), 1);
    check("R1", "pos at 24-bit sync end", int'(bit_pos), 23);
    payload();
    send_sync(33'h0);
    check("R4", "lock threshold 0 acts as 1", int'(sync_state), 2);
    payload();
    send_sync(33'h0000100);
    check("R2", "one error with tolerance 0 is a miss", int'(sync_state), 0);
    check("R9", "event on loss threshold 1", int'(lock_evt), 1);
    zeros(12);
    finish_run();
  end
endmodule